// File: doc/BRIEF.md
# Tiled Character Display Generator

This block sits between a raster timing source and a one-bit-per-pixel font memory. For every pixel coordinate it receives, it forms the address of the matching glyph bit in a 128-glyph font of 16x16 cells. It then turns the bit that the memory returns into a three-bit colour. The character code is derived from the screen position of the cell, so a screen fed by this block shows the whole glyph set in order, tiled over as many cell rows as the raster holds.

Two slicings of the coordinates are available at run time. In normal mode each glyph occupies 16x16 screen pixels and 32 glyphs fill a cell row. In doubled mode each font bit covers a 2x2 pixel square, so a cell is 32x32 pixels and 16 glyphs fill a cell row. The font memory answers one clock after it is addressed. The block holds the visibility flag and both colour selects back by that latency so that they meet the returned bit, and it registers the colour outputs. A colour therefore appears two clocks after its coordinates were presented.

Top module: `char_tile_gen`

## Requirements
- R1: `font_addr` is a combinational function of the coordinates and mode presented in the same cycle. Its bits [14:8] carry the 7-bit character code, bits [7:4] the glyph row and bits [3:0] the glyph column.
- R2: With `scale_2x` = 0, the glyph column is `pix_col[3:0]`, the glyph row is `pix_row[3:0]`, and the code is `pix_row[5:4]*32 + pix_col[8:4]`.
- R3: With `scale_2x` = 1, the glyph column is `pix_col[4:1]`, the glyph row is `pix_row[4:1]`, and the code is `pix_row[7:5]*16 + pix_col[8:5]`.
- R4: Coordinate bits above those named in R2 and R3 do not affect the address, so the glyph sequence repeats across further cell rows and columns.
- R5: When the font bit for a visible pixel is 1, the output colour equals `fg_sel`, with bit 0 driving red, bit 1 green and bit 2 blue.
- R6: When the font bit for a visible pixel is 0, the output colour is the bitwise inverse of `bg_sel`, with the same bit mapping.
- R7: When `visible` was 0 for a pixel, all three colour outputs are 0 for that pixel.
- R8: The colour for the inputs of cycle n appears on the outputs in cycle n+2. The font bit used is the one the memory returns in cycle n+1 for the address of cycle n.
- R9: While `rst` is high, and for the two cycles after it falls, the colour outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_col | input | 11 | Current pixel column |
| pix_row | input | 10 | Current pixel row |
| visible | input | 1 | High while the pixel lies in the displayed area |
| font_bit | input | 1 | Glyph bit returned by the font memory, one clock after its address |
| scale_2x | input | 1 | 0: 16x16 cells, 1: each font bit drawn as 2x2 pixels |
| fg_sel | input | 3 | Foreground colour {blue, green, red} |
| bg_sel | input | 3 | Background select, shown inverted |
| font_addr | output | 15 | {code, glyph row, glyph column} to the font memory |
| red | output | 1 | Registered red output |
| green | output | 1 | Registered green output |
| blue | output | 1 | Registered blue output |

## Verification
On every clock, the embedded properties check three things: that the delayed attributes equal the inputs one memory latency earlier, that blanked pixels come out dark, and that a lit or unlit font bit selects the foreground or the inverted background. The address slicing in both modes, the wrap of higher coordinate bits and the two-cycle alignment of colour changes against real coordinates are shown only by the bench. Its reference computes cell indices arithmetically, models the font memory and compares every cycle. It sweeps whole lines in both modes, including rows and columns past the glyph set, toggles the mode cycle by cycle and changes colour selects mid-line.

// File: rtl/ctg_pkg.sv
`timescale 1ns/1ps
package ctg_pkg;

   // Per-pixel attributes that must travel alongside the font read.
   typedef struct packed {
      logic       vis;
      logic [2:0] fg;
      logic [2:0] bg;
   } ctg_attr_t;

   localparam int unsigned CTG_RGB_W = 3;

endpackage

// File: rtl/ctg_addr_map.sv
`timescale 1ns/1ps
module ctg_addr_map #(
   parameter int unsigned COL_W     = 11,
   parameter int unsigned ROW_W     = 10,
   parameter int unsigned GLYPH_W   = 4,
   parameter int unsigned CODE_W    = 7,
   parameter int unsigned NCOL_BITS = 5,
   parameter bit          SCALE_EN  = 1'b1,
   localparam int unsigned ADDR_W   = CODE_W + 2 * GLYPH_W
) (
   input  logic [COL_W-1:0]  col,
   input  logic [ROW_W-1:0]  row,
   input  logic              scale,
   output logic [ADDR_W-1:0] addr
);

   localparam int unsigned NROW_BITS = CODE_W - NCOL_BITS;

   if (COL_W < GLYPH_W + NCOL_BITS + 1) begin : g_chk_col
      $error("ctg_addr_map: COL_W too small for the cell grid");
   end
   if (ROW_W < GLYPH_W + NROW_BITS + 2) begin : g_chk_row
      $error("ctg_addr_map: ROW_W too small for the cell grid");
   end
   if (NCOL_BITS < 2 || NCOL_BITS >= CODE_W) begin : g_chk_split
      $error("ctg_addr_map: NCOL_BITS must leave room for cell-row bits");
   end

   // Normal slicing: one font bit per screen pixel.
   logic [CODE_W-1:0]  code_n;
   logic [GLYPH_W-1:0] grow_n, gcol_n;

   always_comb begin
      code_n = {row[GLYPH_W +: NROW_BITS], col[GLYPH_W +: NCOL_BITS]};
      grow_n = row[0 +: GLYPH_W];
      gcol_n = col[0 +: GLYPH_W];
   end

   if (SCALE_EN) begin : g_scaled
      // Doubled slicing: drop the lowest coordinate bit, one more cell-row
      // bit and one fewer cell-column bit so the code stays CODE_W wide.
      logic [CODE_W-1:0]  code_s;
      logic [GLYPH_W-1:0] grow_s, gcol_s;

      always_comb begin
         code_s = {row[GLYPH_W + 1 +: NROW_BITS + 1],
                   col[GLYPH_W + 1 +: NCOL_BITS - 1]};
         grow_s = row[1 +: GLYPH_W];
         gcol_s = col[1 +: GLYPH_W];
         if (scale) addr = {code_s, grow_s, gcol_s};
         else       addr = {code_n, grow_n, gcol_n};
      end
   end else begin : g_plain
      always_comb addr = {code_n, grow_n, gcol_n};
   end

   // Upper coordinate bits are deliberately dropped so the glyph set wraps.
   wire unused_bits = ^{col, row, scale};

endmodule

// File: rtl/ctg_align.sv
`timescale 1ns/1ps
module ctg_align
   import ctg_pkg::*;
#(
   parameter int unsigned LAT = 1
) (
   input  logic      clk,
   input  logic      rst,
   input  ctg_attr_t din,
   output ctg_attr_t dout
);

   if (LAT < 1 || LAT > 8) begin : g_chk_lat
      $error("ctg_align: LAT must be between 1 and 8");
   end

   localparam int unsigned CW = $clog2(LAT + 1);

   for (genvar i = 0; i < LAT; i++) begin : g_stage
      ctg_attr_t q;
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= din;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= g_stage[i-1].q;
         end
      end
   end

   assign dout = g_stage[LAT-1].q;

   // Count cycles since reset so the delay check never reaches into reset.
   logic [CW-1:0] fill_q;
   always_ff @(posedge clk) begin
      if (rst)                        fill_q <= '0;
      else if (fill_q != CW'(LAT))    fill_q <= fill_q + 1'b1;
   end

   AST_ALIGN_DELAY: assert property (@(posedge clk) disable iff (rst)
      (fill_q == CW'(LAT)) |-> (dout == $past(din, LAT))) // R8
      else $error("AST_ALIGN_DELAY");

endmodule

// File: rtl/ctg_colour.sv
`timescale 1ns/1ps
module ctg_colour
   import ctg_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  ctg_attr_t       attr,
   input  logic            font_bit,
   output logic [CTG_RGB_W-1:0] rgb
);

   always_ff @(posedge clk) begin
      if (rst)              rgb <= '0;
      else if (!attr.vis)   rgb <= '0;
      else if (font_bit)    rgb <= attr.fg;
      else                  rgb <= ~attr.bg;
   end

   AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
      !attr.vis |=> (rgb == '0)) // R7
      else $error("AST_BLANK_DARK");

   AST_FG_PATH: assert property (@(posedge clk) disable iff (rst)
      (attr.vis && font_bit) |=> (rgb == $past(attr.fg))) // R5
      else $error("AST_FG_PATH");

   AST_BG_PATH: assert property (@(posedge clk) disable iff (rst)
      (attr.vis && !font_bit) |=> (rgb == ~$past(attr.bg))) // R6
      else $error("AST_BG_PATH");

   AST_RESET_DARK: assert property (@(posedge clk)
      rst |=> (rgb == '0)) // R9
      else $error("AST_RESET_DARK");

endmodule

// File: rtl/char_tile_gen.sv
`timescale 1ns/1ps
module char_tile_gen
   import ctg_pkg::*;
#(
   parameter int unsigned COL_W     = 11,
   parameter int unsigned ROW_W     = 10,
   parameter int unsigned GLYPH_W   = 4,
   parameter int unsigned CODE_W    = 7,
   parameter int unsigned NCOL_BITS = 5,
   parameter int unsigned ROM_LAT   = 1,
   parameter bit          SCALE_EN  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [COL_W-1:0]              pix_col,
   input  logic [ROW_W-1:0]              pix_row,
   input  logic                          visible,
   input  logic                          font_bit,
   input  logic                          scale_2x,
   input  logic [2:0]                    fg_sel,
   input  logic [2:0]                    bg_sel,
   output logic [CODE_W+2*GLYPH_W-1:0]   font_addr,
   output logic                          red,
   output logic                          green,
   output logic                          blue
);

   localparam int unsigned ADDR_W = CODE_W + 2 * GLYPH_W;

   if (ADDR_W != $bits(font_addr)) begin : g_chk_addr
      $error("char_tile_gen: address width mismatch");
   end

   ctg_attr_t                attr_now, attr_al;
   logic [CTG_RGB_W-1:0]     rgb_q;

   ctg_addr_map #(
      .COL_W     (COL_W),
      .ROW_W     (ROW_W),
      .GLYPH_W   (GLYPH_W),
      .CODE_W    (CODE_W),
      .NCOL_BITS (NCOL_BITS),
      .SCALE_EN  (SCALE_EN)
   ) u_addr (
      .col   (pix_col),
      .row   (pix_row),
      .scale (scale_2x),
      .addr  (font_addr)
   );

   always_comb begin
      attr_now.vis = visible;
      attr_now.fg  = fg_sel;
      attr_now.bg  = bg_sel;
   end

   ctg_align #(
      .LAT (ROM_LAT)
   ) u_align (
      .clk  (clk),
      .rst  (rst),
      .din  (attr_now),
      .dout (attr_al)
   );

   ctg_colour u_colour (
      .clk      (clk),
      .rst      (rst),
      .attr     (attr_al),
      .font_bit (font_bit),
      .rgb      (rgb_q)
   );

   assign red   = rgb_q[0];
   assign green = rgb_q[1];
   assign blue  = rgb_q[2];

endmodule

// File: tb/char_tile_gen_tb_top.sv
`timescale 1ns/1ps
module char_tile_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic [10:0] pix_col;
   logic [9:0]  pix_row;
   logic        visible;
   logic        font_bit;
   logic        scale_2x;
   logic [2:0]  fg_sel, bg_sel;
   logic [14:0] font_addr;
   logic        red, green, blue;

   always #2.5 clk = ~clk;

   char_tile_gen dut_i (
      .clk(clk), .rst(rst), .pix_col(pix_col), .pix_row(pix_row),
      .visible(visible), .font_bit(font_bit), .scale_2x(scale_2x),
      .fg_sel(fg_sel), .bg_sel(bg_sel), .font_addr(font_addr),
      .red(red), .green(green), .blue(blue)
   );

   int vectors = 0;
   int miscompares = 0;
   bit running = 1'b0;
   bit done = 1'b0;

   // Behavioural font memory: a scrambled pattern, one clock of read latency.
   function automatic logic glyph(input int a);
      int v;
      v = ((a >> 8) & 127) * 5 + ((a >> 4) & 15) * 3 + (a & 15);
      return (v % 7) < 3;
   endfunction

   logic rom_q;
   always @(posedge clk) rom_q <= glyph(int'(font_addr));
   assign font_bit = rom_q;

   function automatic int ref_addr(input int c, input int r, input bit s);
      int code, gr, gc;
      if (s) begin
         code = ((r >> 5) & 7) * 16 + ((c >> 5) & 15);
         gr   = (r >> 1) & 15;
         gc   = (c >> 1) & 15;
      end else begin
         code = ((r >> 4) & 3) * 32 + ((c >> 4) & 31);
         gr   = r & 15;
         gc   = c & 15;
      end
      return code * 256 + gr * 16 + gc;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   typedef struct { int vis; int fg; int bg; int fbit; } pix_t;
   pix_t q[$];
   pix_t e;
   int   ea, exp_rgb;
   string atag, ctag;

   // Cycle-by-cycle reference, sampled mid-cycle.
   always @(negedge clk) begin
      if (running && !rst) begin
         ea = ref_addr(int'(pix_col), int'(pix_row), scale_2x);
         if (pix_col >= 512 || (!scale_2x && pix_row >= 64) ||
             (scale_2x && pix_row >= 256))
            atag = "R4 address wrap";
         else if (scale_2x) atag = "R1/R3 doubled address";
         else               atag = "R1/R2 normal address";
         check(atag, int'(font_addr), ea);
         q.push_back('{int'(visible), int'(fg_sel), int'(bg_sel),
                       int'(glyph(ea))});
         if (q.size() >= 3) begin
            e = q.pop_front();
            if (e.vis == 0) begin
               exp_rgb = 0; ctag = "R7/R8 blank";
            end else if (e.fbit != 0) begin
               exp_rgb = e.fg; ctag = "R5/R8 foreground";
            end else begin
               exp_rgb = (~e.bg) & 7; ctag = "R6/R8 background";
            end
         end else begin
            exp_rgb = 0; ctag = "R9 after reset";
         end
         check(ctag, int'({blue, green, red}), exp_rgb);
      end
   end

   task automatic drive(input int c, input int r, input bit v,
                        input int f, input int b, input bit s);
      @(posedge clk);
      #1;
      pix_col  = 11'(c);
      pix_row  = 10'(r);
      visible  = v;
      fg_sel   = 3'(f);
      bg_sel   = 3'(b);
      scale_2x = s;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int rows_n[8] = '{0, 5, 17, 40, 63, 64, 130, 599};
      int rows_s[8] = '{0, 3, 33, 100, 255, 256, 300, 599};
      rst = 1'b1;
      pix_col = '0; pix_row = '0; visible = 1'b1;
      fg_sel = 3'd5; bg_sel = 3'd2; scale_2x = 1'b0;
      repeat (4) begin
         @(negedge clk);
         check("R9 in reset", int'({blue, green, red}), 0);
      end
      @(posedge clk);
      #1;
      rst = 1'b0;
      running = 1'b1;

      // Normal mode: full lines including blanking and columns past 511.
      foreach (rows_n[k]) begin
         for (int c = 0; c < 1040; c++)
            drive(c, rows_n[k], (c < 800) && (c % 97 < 80),
                  (c / 50) % 8, (c / 37) % 8, 1'b0);
      end

      // Doubled mode.
      foreach (rows_s[k]) begin
         for (int c = 0; c < 1040; c++)
            drive(c, rows_s[k], (c < 800) && (c % 61 < 50),
                  (c / 23) % 8, (c / 41) % 8, 1'b1);
      end

      // Mode and colours changing every cycle.
      for (int i = 0; i < 2000; i++)
         drive((i * 7) % 1040, (i * 13) % 600, (i % 5) != 0,
               i % 8, (i / 3) % 8, i[0]);

      // Drain the pipeline with blanked pixels.
      for (int i = 0; i < 4; i++)
         drive(0, 0, 1'b0, 0, 0, 1'b0);

      running = 1'b0;
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule